// File: doc/BRIEF.md
# Debug Event Request/Acknowledge Controller

This block manages one shared, active-low, open-drain debug-event pin. A pull-up holds the pin high when idle. An external agent asks for debug entry by pulling the pin low. An internal breakpoint comparator can ask for the same thing through a one-cycle match input. The block does not halt the core at once. It first asks the core to stall and waits until the core reports that the current instruction has retired. It then requests a single-cycle save of the pipeline state. After that it reports the halted condition to the debug logic.

On entering the halted state the block pulls the pin low for exactly three clocks. This acknowledges entry whatever the cause. Its own low pulse on the wired pin must not be taken back as a new request, so the edge detector is blinded during the pulse and for one cycle after it. While halted, the block waits for an exit command from the serial debug path. That command releases the stall and returns the block to the running state.

Top module: `dbg_event_ctrl`

## Requirements
- R1: While reset is asserted, and at once when it is asserted during an acknowledge, `dbg_pin_oe`, `stall_req`, `save_req` and `halted` are all 0.
- R2: A high-to-low transition of `dbg_pin_i` in the running state raises `stall_req` on the third rising clock edge after the low level is first sampled. The pin passes through two synchroniser flops and one edge flop. A pin held low raises no further request.
- R3: A one-cycle `bkpt_hit` pulse in the running state raises `stall_req` on the next rising edge.
- R4: `save_req` stays 0 while the core has not reported retirement. It is 1 for exactly one cycle, the cycle after `instr_done` is sampled high in the waiting state.
- R5: `dbg_pin_oe` (1 = pull the pin low) rises in the same cycle as `halted` and stays high for exactly three consecutive cycles.
- R6: The three-cycle acknowledge is the same whether entry was caused by the pin or by a breakpoint.
- R7: A pin request or a `bkpt_hit` that arrives while the block is waiting, saving or halted has no effect: no second acknowledge, and `halted` stays 1.
- R8: `exit_cmd` sampled while halted clears `stall_req` and `halted` on the next edge. `exit_cmd` in any other state is ignored.
- R9: The block's own acknowledge, read back through the wired pin, never causes a new entry, even when exit happens during the acknowledge.
- R10: `stall_req` is 1 in every state other than running: waiting, saving and halted.
- R11: A pin request and a breakpoint that arrive close together produce a single entry with a single three-cycle acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_pin_i | input | 1 | Level read back from the shared pin (pulled up, active low) |
| bkpt_hit | input | 1 | One-cycle breakpoint match |
| instr_done | input | 1 | Core reports that the instruction in progress has retired |
| exit_cmd | input | 1 | Exit-debug command from the serial debug path |
| dbg_pin_oe | output | 1 | Open-drain enable; 1 pulls the pin low |
| stall_req | output | 1 | Ask the core to stop issuing instructions |
| save_req | output | 1 | One-cycle request to save the pipeline state |
| halted | output | 1 | Core is in debug mode |

## Verification
Two functions can act in the same cycle. One is the acknowledge pulse driving the pin low. The other is the edge detector looking at that same pin, because the bench models the pin as a wired-AND of the external driver and `dbg_pin_oe`. The bench sends the exit command in the first acknowledge cycle. The state is then running while the block's own falling edge reaches the detector. The bench judges the result by requiring that `stall_req` stays low for several cycles afterwards. A second overlap is a pin request and a breakpoint arriving together. The bench judges that by counting exactly three acknowledge cycles in total.

// File: rtl/dbgev_pkg.sv
`timescale 1ns/1ps
package dbgev_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_SAVE = 2'd2,
    ST_HALT = 2'd3
  } dbg_state_e;

  // Sequencer transition: requests only count while running,
  // retirement only while waiting, exit only while halted.
  function automatic dbg_state_e seq_next(input dbg_state_e cur,
                                          input logic       req,
                                          input logic       done,
                                          input logic       leave);
    dbg_state_e nxt;
    nxt = cur;
    unique case (cur)
      ST_RUN:  if (req)   nxt = ST_WAIT;
      ST_WAIT: if (done)  nxt = ST_SAVE;
      ST_SAVE:            nxt = ST_HALT;
      ST_HALT: if (leave) nxt = ST_RUN;
      default:            nxt = ST_RUN;
    endcase
    return nxt;
  endfunction

  // Count-down step for the acknowledge and blind timers.
  function automatic int unsigned tick_down(input int unsigned v);
    return (v == 0) ? 0 : v - 1;
  endfunction

endpackage

// File: rtl/dbgev_sync.sv
`timescale 1ns/1ps
module dbgev_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_i,
  input  logic blind_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= pad_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], pad_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain[STAGES-1];
  end

  assign level_o = chain[STAGES-1];
  assign fall_o  = prev_q & ~chain[STAGES-1] & ~blind_i;
endmodule

// File: rtl/dbgev_seq.sv
`timescale 1ns/1ps
module dbgev_seq
  import dbgev_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       done_i,
  input  logic       exit_i,
  output dbg_state_e state_o,
  output logic       ack_start_o
);
  dbg_state_e state_q;
  dbg_state_e state_d;

  always_comb state_d = seq_next(state_q, req_i, done_i, exit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign state_o     = state_q;
  assign ack_start_o = (state_q == ST_SAVE);
endmodule

// File: rtl/dbgev_ack.sv
`timescale 1ns/1ps
module dbgev_ack
  import dbgev_pkg::*;
#(
  parameter int ACK_CYCLES = 3,
  parameter int TAIL       = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic oe_o,
  output logic blind_o
);
  localparam int CW = $clog2(ACK_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          last_w;

  assign last_w = (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (start_i) cnt_q <= CW'(ACK_CYCLES);
    else              cnt_q <= CW'(tick_down(int'(cnt_q)));
  end

  assign oe_o = (cnt_q != '0);

  generate
    if (TAIL > 0) begin : g_tail
      localparam int TW = $clog2(TAIL + 1);
      logic [TW-1:0] tail_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  tail_q <= '0;
        else if (last_w && !start_i) tail_q <= TW'(TAIL);
        else                         tail_q <= TW'(tick_down(int'(tail_q)));
      end
      assign blind_o = oe_o | (tail_q != '0);
    end else begin : g_notail
      assign blind_o = oe_o;
    end
  endgenerate
endmodule

// File: rtl/dbg_event_ctrl.sv
`timescale 1ns/1ps
module dbg_event_ctrl
  import dbgev_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ACK_CYCLES  = 3,
  parameter int BLIND_TAIL  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_pin_i,
  input  logic bkpt_hit,
  input  logic instr_done,
  input  logic exit_cmd,
  output logic dbg_pin_oe,
  output logic stall_req,
  output logic save_req,
  output logic halted
);
  // named internal events, visible to the bound checker
  logic       pin_level;
  logic       pin_fall;
  logic       ack_blind;
  logic       ack_start;
  logic       entry_req;
  dbg_state_e state;

  dbgev_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pad_i   (dbg_pin_i),
    .blind_i (ack_blind),
    .level_o (pin_level),
    .fall_o  (pin_fall)
  );

  assign entry_req = pin_fall | bkpt_hit;

  dbgev_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (entry_req),
    .done_i      (instr_done),
    .exit_i      (exit_cmd),
    .state_o     (state),
    .ack_start_o (ack_start)
  );

  dbgev_ack #(.ACK_CYCLES(ACK_CYCLES), .TAIL(BLIND_TAIL)) u_ack (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (ack_start),
    .oe_o    (dbg_pin_oe),
    .blind_o (ack_blind)
  );

  assign stall_req = (state != ST_RUN);
  assign save_req  = (state == ST_SAVE);
  assign halted    = (state == ST_HALT);
endmodule

// File: rtl/dbgev_chk.sv
`timescale 1ns/1ps
module dbgev_chk #(
  parameter int ACK_CYCLES = 3
) (
  input logic clk,
  input logic rst_n,
  input logic bkpt_hit,
  input logic instr_done,
  input logic exit_cmd,
  input logic dbg_pin_oe,
  input logic stall_req,
  input logic save_req,
  input logic halted,
  input logic ack_blind
);
  logic [7:0] oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          oe_run <= '0;
    else if (dbg_pin_oe) oe_run <= oe_run + 8'd1;
    else                 oe_run <= '0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!dbg_pin_oe && !stall_req && !halted)); // R1
  AST_SAVE_AFTER_RETIRE: assert property (@(posedge clk) disable iff (!rst_n) $rose(save_req) |-> $past(instr_done)); // R4
  AST_SAVE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) save_req |=> !save_req); // R4
  AST_ACK_WITH_HALT: assert property (@(posedge clk) disable iff (!rst_n) $rose(dbg_pin_oe) |-> $rose(halted)); // R5
  AST_ACK_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(dbg_pin_oe) |-> (oe_run == 8'(ACK_CYCLES))); // R5
  AST_ACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n) oe_run <= 8'(ACK_CYCLES)); // R6
  AST_EXIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (halted && exit_cmd) |=> !stall_req); // R8
  AST_NO_SELF_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n) $rose(stall_req) |-> (!$past(ack_blind) || $past(bkpt_hit))); // R9
  AST_HALT_STALLS: assert property (@(posedge clk) disable iff (!rst_n) (halted || save_req) |-> stall_req); // R10
endmodule

bind dbg_event_ctrl dbgev_chk #(.ACK_CYCLES(ACK_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bkpt_hit   (bkpt_hit),
  .instr_done (instr_done),
  .exit_cmd   (exit_cmd),
  .dbg_pin_oe (dbg_pin_oe),
  .stall_req  (stall_req),
  .save_req   (save_req),
  .halted     (halted),
  .ack_blind  (ack_blind)
);

// File: tb/sim_dbg_event_ctrl.sv
`timescale 1ns/1ps
module sim_dbg_event_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_n = 1'b1;
  logic bkpt_hit = 1'b0;
  logic instr_done = 1'b0;
  logic exit_cmd = 1'b0;
  logic dbg_pin_oe, stall_req, save_req, halted;
  logic pin;
  int   nchk = 0;
  int   nfail = 0;
  bit   finished = 0;

  always #5 clk = ~clk;

  // wired-AND open-drain pin with pull-up
  assign pin = ext_n & ~dbg_pin_oe;

  dbg_event_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .dbg_pin_i(pin), .bkpt_hit(bkpt_hit),
    .instr_done(instr_done), .exit_cmd(exit_cmd), .dbg_pin_oe(dbg_pin_oe),
    .stall_req(stall_req), .save_req(save_req), .halted(halted)
  );

  // {source[1:0] (0 pin,1 bkpt,2 both), hold[3:0], exit_in_ack, latency[3:0]}
  localparam logic [10:0] VEC [6] = '{
    {2'd0, 4'd0, 1'b0, 4'd3},
    {2'd1, 4'd2, 1'b0, 4'd1},
    {2'd2, 4'd1, 1'b0, 4'd1},
    {2'd0, 4'd4, 1'b1, 4'd3},
    {2'd1, 4'd0, 1'b1, 4'd1},
    {2'd2, 4'd3, 1'b1, 4'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int i);
    logic [1:0] src;
    logic [3:0] hold;
    logic       early;
    logic [3:0] lat_exp;
    int lat, oecnt, stray;
    src = VEC[i][10:9]; hold = VEC[i][8:5]; early = VEC[i][4]; lat_exp = VEC[i][3:0];
    @(negedge clk);
    if (src != 2'd1) ext_n = 1'b0;
    if (src != 2'd0) bkpt_hit = 1'b1;
    lat = 0;
    for (int k = 1; k <= 8 && lat == 0; k++) begin
      @(negedge clk);
      bkpt_hit = 1'b0;
      if (stall_req) lat = k;
    end
    ext_n = 1'b1;
    chk(lat == int'(lat_exp), "R2 R3 entry latency", lat, int'(lat_exp));
    for (int k = 0; k < int'(hold); k++) begin
      chk(!save_req, "R4 save before retire", save_req, 0);
      chk(stall_req, "R10 stall while waiting", stall_req, 1);
      @(negedge clk);
    end
    instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0;
    chk(save_req && !halted, "R4 save after retire", save_req, 1);
    @(negedge clk);
    chk(halted && dbg_pin_oe && !save_req, "R5 halt with ack", {halted, dbg_pin_oe}, 3);
    oecnt = 0;
    for (int k = 0; k < 8; k++) begin
      if (dbg_pin_oe) oecnt++;
      if (k == 1 && early) chk(!stall_req, "R8 exit during ack", stall_req, 0);
      exit_cmd = (k == 0) && early;
      bkpt_hit = (k == 1) && !early;
      if (!early && k == 4) ext_n = 1'b0;
      if (k == 6) ext_n = 1'b1;
      @(negedge clk);
    end
    exit_cmd = 1'b0; bkpt_hit = 1'b0;
    chk(oecnt == 3, "R5 R6 R11 ack length", oecnt, 3);
    if (!early) begin
      chk(halted, "R7 request ignored while halted", halted, 1);
      exit_cmd = 1'b1;
      @(negedge clk);
      exit_cmd = 1'b0;
      chk(!stall_req && !halted, "R8 exit from halt", stall_req, 0);
    end
    stray = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (stall_req || dbg_pin_oe) stray++;
    end
    chk(stray == 0, "R9 no re-entry from own ack", stray, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    chk(!dbg_pin_oe && !stall_req && !save_req && !halted, "R1 reset state",
        {dbg_pin_oe, stall_req, save_req, halted}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 6; i++) run_vec(i);

    // R8: exit outside halt is ignored
    bkpt_hit = 1'b1;
    @(negedge clk);
    bkpt_hit = 1'b0; exit_cmd = 1'b1;
    @(negedge clk);
    exit_cmd = 1'b0;
    chk(stall_req && !halted, "R8 exit ignored while waiting", stall_req, 1);
    instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0;
    @(negedge clk);
    chk(halted, "R8 halt after ignored exit", halted, 1);
    repeat (5) @(negedge clk);
    exit_cmd = 1'b1;
    @(negedge clk);
    exit_cmd = 1'b0;
    repeat (4) @(negedge clk);

    // R2: pin held low gives one request only
    ext_n = 1'b0; instr_done = 1'b1;
    lat = 0;
    for (int k = 1; k <= 8 && lat == 0; k++) begin
      @(negedge clk);
      if (stall_req) lat = k;
    end
    chk(lat == 3, "R2 held-low entry latency", lat, 3);
    repeat (7) @(negedge clk);
    instr_done = 1'b0;
    chk(halted, "R2 halted with pin held low", halted, 1);
    exit_cmd = 1'b1;
    @(negedge clk);
    exit_cmd = 1'b0;
    lat = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (stall_req) lat++;
    end
    chk(lat == 0, "R2 held level no new request", lat, 0);
    ext_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!stall_req, "R2 rising edge no request", stall_req, 0);

    // R1: reset asserted mid-acknowledge
    bkpt_hit = 1'b1;
    @(negedge clk);
    bkpt_hit = 1'b0; instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0;
    @(negedge clk);
    chk(dbg_pin_oe, "R5 ack before reset", dbg_pin_oe, 1);
    rst_n = 1'b0;
    #1;
    chk(!dbg_pin_oe && !stall_req && !halted && !save_req, "R1 reset during ack",
        {dbg_pin_oe, stall_req, halted, save_req}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!stall_req && !dbg_pin_oe, "R1 idle after reset", stall_req, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule